// File: doc/BRIEF.md
# Interrupt Status and Enable Register Pair

This block holds the interrupt state of a serial link datapath in two byte-wide registers on a simple register bus. The bus has an address, a write strobe, write data and read data. Five single-cycle event pulses from the datapath are caught in sticky status bits:

- transmit complete
- receive complete
- transmit starved
- receive overrun
- serial gap detected

Software chooses which sources may raise the interrupt line through a companion enable register. It acknowledges events by writing ones to the status register.

The five event bits occupy the upper part of each byte. The bits below them are tied off and always read as ones. Status bits capture events whether or not their source is enabled. The enable register only gates the single level-sensitive interrupt output, which stays high while any enabled status bit is set. Reads are combinational from the address. Addresses other than the two register offsets read as zero and ignore writes.

Top module: `irq_regpair`

## Requirements
- R1: After reset the status register (offset 0xc) and the enable register (offset 0xd) both read 0x07, and irq_out is low.
- R2: The status register decodes at offset 0xc and the enable register at offset 0xd. Every other offset reads 0x00.
- R3: evt_pulse bit 4 (transmit complete) sets register bit 7. Bit 3 (receive complete) sets bit 6. Bit 2 (transmit starved) sets bit 5. Bit 1 (receive overrun) sets bit 4. Bit 0 (serial gap) sets bit 3. Each is visible on the read port in the cycle after the pulse is sampled.
- R4: Bits 2..0 of both registers always read 1, whatever value is written to them.
- R5: Writing to offset 0xc clears each status bit whose write-data bit is 1 and leaves status bits written with 0 unchanged.
- R6: A write to offset 0xd loads write-data bits 7..3 into the enable register. A 1 enables that source and a 0 disables it.
- R7: When an event pulse and a clearing write to the same status bit arrive in the same cycle, the bit ends up set.
- R8: Status bits latch events and stay set independently of the enable register contents.
- R9: irq_out is high exactly while at least one status bit and its matching enable bit are both 1.
- R10: A write to any offset other than 0xc or 0xd changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| evt_pulse | input | 5 | Event pulses: [4] tx complete, [3] rx complete, [2] tx starved, [1] rx overrun, [0] serial gap |
| irq_out | output | 1 | Level interrupt request |

## Verification
Each event line is pulsed alone after a full clear. This separates a correct bit mapping from swapped or shifted lanes.

Partial write-one-to-clear patterns such as 0x50 against a full status byte show whether zeros are truly ignored, as opposed to the register being overwritten. Collisions between an event and a clear of the same bit pin down the priority.

Writes of all ones to the tied-off bits and to foreign offsets show that nothing leaks into the stored state. A seeded random mix of reads, writes and sparse events runs against a bench model. It catches interactions between enabling and latching that the directed cases miss, and it checks the interrupt line after every step.

// File: rtl/irq_regpair_pkg.sv
package irq_regpair_pkg;

   localparam int unsigned IRQ_DATA_W   = 8;
   localparam int unsigned IRQ_NUM_SRC  = 5;
   localparam int unsigned IRQ_ADDR_W   = 5;
   localparam int unsigned IRQ_STAT_OFS = 'hc;
   localparam int unsigned IRQ_EN_OFS   = 'hd;

   typedef enum logic [1:0] {
      RSEL_NONE = 2'd0,
      RSEL_STAT = 2'd1,
      RSEL_EN   = 2'd2
   } rsel_e;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
   import irq_regpair_pkg::*;
#(
   parameter int unsigned ADDR_W   = IRQ_ADDR_W,
   parameter int unsigned STAT_OFS = IRQ_STAT_OFS,
   parameter int unsigned EN_OFS   = IRQ_EN_OFS
) (
   input  logic [ADDR_W-1:0] addr,
   output rsel_e             sel
);

   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_OFS);

   if (STAT_OFS == EN_OFS) begin : g_bad_ofs
      $error("irq_addr_decode: status and enable offsets collide");
   end
   if (STAT_OFS >= (1 << ADDR_W) || EN_OFS >= (1 << ADDR_W)) begin : g_bad_range
      $error("irq_addr_decode: offset does not fit ADDR_W");
   end

   always_comb begin
      if (addr == STAT_A)    sel = RSEL_STAT;
      else if (addr == EN_A) sel = RSEL_EN;
      else                   sel = RSEL_NONE;
   end

endmodule

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic clr,
   output logic q
);

   always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= evt | (q & ~clr);
   end

   // R7: an event beats a simultaneous clear
   a_r7_event_wins : assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> q);
   // R5: a clear without an event empties the bit
   a_r5_clear_drops : assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !evt) |=> !q);
   // R8: a set bit holds until it is cleared
   a_r8_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr) |=> q);

endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
   parameter int unsigned NUM_SRC = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [NUM_SRC-1:0] din,
   output logic [NUM_SRC-1:0] en
);

   if (NUM_SRC == 0) begin : g_bad_n
      $error("irq_enable_bank: NUM_SRC must be nonzero");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    en <= '0;
      else if (load) en <= din;
   end

   // R6: a load takes the written value
   a_r6_enable_load : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (en == $past(din)));
   // R10: without a load the bank holds
   a_r10_enable_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(en));

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
   import irq_regpair_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_SRC   = 5,
   parameter bit          FILL_ONES = 1'b1
) (
   input  rsel_e              sel,
   input  logic [NUM_SRC-1:0] stat,
   input  logic [NUM_SRC-1:0] en,
   output logic [DATA_W-1:0]  rdata
);

   localparam int unsigned LSB_W = DATA_W - NUM_SRC;

   logic [LSB_W-1:0] fill;

   if (LSB_W == 0 || NUM_SRC >= DATA_W) begin : g_bad_w
      $error("irq_read_mux: need at least one tied-off low bit");
   end

   if (FILL_ONES) begin : g_fill_one
      assign fill = '1;
   end else begin : g_fill_zero
      assign fill = '0;
   end

   always_comb begin
      unique case (sel)
         RSEL_STAT: rdata = {stat, fill};
         RSEL_EN:   rdata = {en, fill};
         default:   rdata = '0;
      endcase
   end

endmodule

// File: rtl/irq_regpair.sv
module irq_regpair
   import irq_regpair_pkg::*;
#(
   parameter int unsigned DATA_W   = IRQ_DATA_W,
   parameter int unsigned NUM_SRC  = IRQ_NUM_SRC,
   parameter int unsigned ADDR_W   = IRQ_ADDR_W,
   parameter int unsigned STAT_OFS = IRQ_STAT_OFS,
   parameter int unsigned EN_OFS   = IRQ_EN_OFS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_wr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_SRC-1:0] evt_pulse,
   output logic               irq_out
);

   localparam int unsigned LSB = DATA_W - NUM_SRC;

   if (NUM_SRC >= DATA_W) begin : g_bad_fit
      $error("irq_regpair: sources must leave tied-off low bits");
   end

   rsel_e              sel;
   logic [NUM_SRC-1:0] clr_vec;
   logic [NUM_SRC-1:0] stat_vec;
   logic [NUM_SRC-1:0] en_vec;
   logic               wr_stat;
   logic               wr_en;

   irq_addr_decode #(
      .ADDR_W   (ADDR_W),
      .STAT_OFS (STAT_OFS),
      .EN_OFS   (EN_OFS)
   ) u_dec (
      .addr (reg_addr),
      .sel  (sel)
   );

   assign wr_stat = reg_wr && (sel == RSEL_STAT);
   assign wr_en   = reg_wr && (sel == RSEL_EN);
   assign clr_vec = wr_stat ? reg_wdata[DATA_W-1:LSB] : '0;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      irq_sticky_bit u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .evt   (evt_pulse[i]),
         .clr   (clr_vec[i]),
         .q     (stat_vec[i])
      );
   end

   irq_enable_bank #(
      .NUM_SRC (NUM_SRC)
   ) u_en (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (wr_en),
      .din   (reg_wdata[DATA_W-1:LSB]),
      .en    (en_vec)
   );

   irq_read_mux #(
      .DATA_W    (DATA_W),
      .NUM_SRC   (NUM_SRC),
      .FILL_ONES (1'b1)
   ) u_rd (
      .sel   (sel),
      .stat  (stat_vec),
      .en    (en_vec),
      .rdata (reg_rdata)
   );

   assign irq_out = |(stat_vec & en_vec);

   // R3: every sampled event shows up in status next cycle
   a_r3_event_lands : assert property (@(posedge clk) disable iff (!rst_n)
      (evt_pulse != '0) |=> ((stat_vec & $past(evt_pulse)) == $past(evt_pulse)));
   // R4: tied-off bits read as ones at both offsets
   a_r4_low_ones : assert property (@(posedge clk) disable iff (!rst_n)
      (sel != RSEL_NONE) |-> (reg_rdata[LSB-1:0] == '1));
   // R4: low write bits leave the enable bank alone beyond the upper field
   a_r4_low_write_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_wdata[LSB-1:0] != '0) |=> (en_vec == $past(reg_wdata[DATA_W-1:LSB])));
   // R2: foreign offsets read zero
   a_r2_foreign_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (sel == RSEL_NONE) |-> (reg_rdata == '0));
   // R9: the request needs an enabled pending source
   a_r9_irq_needs_source : assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (stat_vec != '0 && en_vec != '0));
   // R10: foreign writes keep status from being cleared
   a_r10_foreign_no_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && sel == RSEL_NONE) |=> ((stat_vec & $past(stat_vec)) == $past(stat_vec)));

endmodule

// File: tb/irq_regpair_tb_top.sv
`timescale 1ns/1ps
module irq_regpair_tb_top;

   localparam logic [4:0] A_STAT = 5'h0c;
   localparam logic [4:0] A_EN   = 5'h0d;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [4:0] reg_addr;
   logic       reg_wr;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;
   logic [4:0] evt_pulse;
   logic       irq_out;

   int   n_checks = 0;
   int   n_errors = 0;
   bit   finished = 1'b0;

   logic [4:0] m_stat;
   logic [4:0] m_en;

   always #4 clk = ~clk;

   irq_regpair dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .evt_pulse (evt_pulse),
      .irq_out   (irq_out)
   );

   function automatic logic [7:0] exp_rd(input logic [4:0] a);
      if (a == A_STAT)    return {m_stat, 3'b111};
      else if (a == A_EN) return {m_en, 3'b111};
      else                return 8'h00;
   endfunction

   function automatic logic exp_irq();
      return |(m_stat & m_en);
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
      end
   endtask

   task automatic do_op(input logic [4:0] a, input logic w, input logic [7:0] d,
                        input logic [4:0] e);
      @(negedge clk);
      reg_addr = a; reg_wr = w; reg_wdata = d; evt_pulse = e;
      @(posedge clk);
      if (w && a == A_STAT) m_stat = e | (m_stat & ~d[7:3]);
      else                  m_stat = m_stat | e;
      if (w && a == A_EN)   m_en = d[7:3];
   endtask

   task automatic rd_check(input logic [4:0] a, input string req);
      @(negedge clk);
      reg_addr = a; reg_wr = 1'b0; evt_pulse = '0;
      #1;
      check(req, reg_rdata, exp_rd(a));
   endtask

   task automatic irq_check(input string req);
      @(negedge clk);
      reg_wr = 1'b0; evt_pulse = '0;
      #1;
      check(req, {7'd0, irq_out}, {7'd0, exp_irq()});
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=running expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'h1c0d_5eed);
      rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; evt_pulse = '0;
      m_stat = '0; m_en = '0;
      repeat (3) @(posedge clk);
      // R1: reset values
      rd_check(A_STAT, "R1 status reset");
      rd_check(A_EN, "R1 enable reset");
      irq_check("R1 irq reset");
      @(negedge clk);
      rst_n = 1'b1;

      // R3: each event lane alone
      for (int i = 0; i < 5; i++) begin
         do_op(A_STAT, 1'b1, 8'hf8, 5'd0);
         do_op(5'h00, 1'b0, 8'h00, 5'(1 << i));
         rd_check(A_STAT, "R3 lane mapping");
      end

      // R8: everything latches with enables off
      do_op(5'h00, 1'b0, 8'h00, 5'h1f);
      rd_check(A_STAT, "R8 latch while disabled");
      irq_check("R8 no irq while disabled");

      // R5: partial write-one-to-clear
      do_op(A_STAT, 1'b1, 8'h50, 5'd0);
      rd_check(A_STAT, "R5 partial clear");

      // R4: low bits ignored on both registers
      do_op(A_STAT, 1'b1, 8'h07, 5'd0);
      rd_check(A_STAT, "R4 status low write");
      do_op(A_EN, 1'b1, 8'hff, 5'd0);
      rd_check(A_EN, "R6 enable all");
      do_op(A_EN, 1'b1, 8'h07, 5'd0);
      rd_check(A_EN, "R4 enable low write");

      // R7: event beats clear on bit 7
      do_op(A_STAT, 1'b1, 8'hf8, 5'd0);
      do_op(A_STAT, 1'b1, 8'h80, 5'h10);
      rd_check(A_STAT, "R7 event wins");

      // R10 and R2: foreign offset
      do_op(5'h0e, 1'b1, 8'hff, 5'd0);
      rd_check(A_STAT, "R10 status after foreign write");
      rd_check(A_EN, "R10 enable after foreign write");
      rd_check(5'h0e, "R2 foreign reads zero");

      // R9: single enabled source raises and drops the line
      do_op(A_STAT, 1'b1, 8'hf8, 5'd0);
      do_op(A_EN, 1'b1, 8'h08, 5'd0);
      do_op(5'h00, 1'b0, 8'h00, 5'h02);
      irq_check("R9 other source no irq");
      do_op(5'h00, 1'b0, 8'h00, 5'h01);
      irq_check("R9 enabled source irq");
      do_op(A_STAT, 1'b1, 8'h08, 5'd0);
      irq_check("R9 irq drops on clear");

      // Random mix
      for (int k = 0; k < 400; k++) begin
         logic [4:0] a;
         logic [4:0] e;
         int unsigned pick;
         pick = $urandom % 4;
         if (pick == 0)      a = A_STAT;
         else if (pick == 1) a = A_EN;
         else if (pick == 2) a = A_STAT;
         else begin
            a = 5'($urandom % 32);
            if (a == A_STAT || a == A_EN) a = 5'h1f;
         end
         e = ($urandom % 3 == 0) ? 5'($urandom) : 5'd0;
         do_op(a, 1'($urandom), 8'($urandom), e);
         rd_check(A_STAT, "R5 random status");
         rd_check(A_EN, "R6 random enable");
         irq_check("R9 random irq");
      end

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule